// File: doc/BRIEF.md
# Threshold-Triggered Transmit Frame Assembler

The block collects a transmit frame that a host writes as 32-bit words into a byte store. Each word adds four bytes, least significant byte first. The first word written into an empty store is special: its low 16 bits give the payload length L. The store then holds two length bytes, a 14-byte header, the payload and, when automatic checksum is off, a 4-byte checksum. Once the frame is on its way out, the block streams it as bytes, one per handshake. The two length bytes are skipped, and short frames can be zero-padded up to 60 bytes.

A frame is launched in one of two ways. It launches automatically when a coded fill threshold is reached and the frame is complete, or it launches when the host writes a transmit request. A launch empties the store and raises a transmit-empty flag. An oversized length word raises a transmit-error flag instead. Both flags sit in a raw status vector that is gated by a mask to form one interrupt line. Register writes use a small write-only port with a 3-bit select.

Top module: `tx_frame_assembler`

## Requirements
- R1: A write with select 4 (data), while `busy` is low, appends its four bytes to the store, least significant byte first. The first word's bits [15:0] are the length L. The streamed frame starts at store byte 2 and is L+14 bytes long, capped at FIFO_BYTES-2.
- R2: A data write into an empty store whose bits [15:0] exceed FIFO_BYTES-16 sets raw status bit 1 and is discarded, so the store stays empty.
- R3: A data write is stored only if at least four free bytes remain. Otherwise it is dropped and earlier bytes are unchanged.
- R4: A frame is complete once the byte count reaches L+16 when control bit 2 (automatic checksum) is set, or L+20 when it is clear. This need is capped at FIFO_BYTES.
- R5: A data write launches the frame automatically only if all three of these hold after the write: the threshold code T (select 3, bits [5:0]) is below 63, the count is at least 4*(8*T+1), and the frame is complete.
- R6: A write with select 5 and bit 0 set launches the current store contents at once. With bit 0 clear it does nothing. An empty store launches as L=0, which is 14 zero bytes.
- R7: When control bit 1 (pad) is set at launch and L+14 is below 60, the frame is extended to 60 bytes with zero bytes.
- R8: At the edge of a launch, the byte count returns to 0, raw status bit 2 is set and `busy` rises.
- R9: A write with select 0 clears the raw status bits that are set in the written value. When bit 1 of the written value is set, the store is also emptied.
- R10: After reset, raw status is 0, the mask is 0x7F, T is 63 and the store is empty. `irq` is high exactly when raw status ANDed with the mask (select 1, bits [6:0]) is nonzero.
- R11: While `busy` is high, `out_valid` is high, and data and last hold steady until `out_ready` is seen. `out_last` marks the final byte and `busy` falls after it. Data and request writes made while `busy` is high are ignored.
- R12: A streamed byte whose store position is at or beyond the written count, or at or beyond L+16, is sent as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Select: 0 ack, 1 mask, 2 control, 3 threshold, 4 data, 5 request |
| wr_data | input | 32 | Write value |
| busy | output | 1 | Frame streaming; data and request writes ignored |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of frame |
| out_ready | input | 1 | Sink accepts byte |
| raw_status | output | 7 | Raw interrupt flags (bit 1 error, bit 2 empty) |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with FIFO_BYTES=128. At that size the length limit is 112, so the oversize boundary, the completeness cap at the full store and a dropped write into a full store are all reached within a few dozen words. Threshold codes 0 and 3 span 4 to 100 bytes at this size. Code 63 keeps frames parked, so manual launches of partial and empty stores can be compared against computed zero fill.

// File: rtl/txa_pkg.sv
package txa_pkg;
  localparam logic [2:0] SEL_ACK  = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_CTRL = 3'd2;
  localparam logic [2:0] SEL_THR  = 3'd3;
  localparam logic [2:0] SEL_DATA = 3'd4;
  localparam logic [2:0] SEL_TRIG = 3'd5;

  localparam int FLAG_W    = 7;
  localparam int ERR_BIT   = 1;
  localparam int EMPTY_BIT = 2;
  localparam int PAD_BIT   = 1;
  localparam int CSUM_BIT  = 2;
  localparam int THR_OFF   = 63;
  localparam int MIN_WIRE  = 60;
  localparam int HDR_BYTES = 14;
  localparam int LEN_BYTES = 2;
  localparam int CSUM_BYTES = 4;

  // bytes the store must hold before the frame counts as complete
  function automatic int need_bytes(int len, bit csum_auto, int cap);
    int n;
    n = len + LEN_BYTES + HDR_BYTES + (csum_auto ? 0 : CSUM_BYTES);
    return (n > cap) ? cap : n;
  endfunction

  function automatic int thr_fill(int code);
    return 4 * (code * 8 + 1);
  endfunction

  function automatic bit thr_armed(int code, int cnt);
    return (code < THR_OFF) && (cnt >= thr_fill(code));
  endfunction

  // number of bytes placed on the output
  function automatic int wire_len(int len, bit pad, int cap);
    int n;
    n = len + HDR_BYTES;
    if (pad && n < MIN_WIRE) n = MIN_WIRE;
    return (n > cap - LEN_BYTES) ? cap - LEN_BYTES : n;
  endfunction

  // store positions below this limit carry real data
  function automatic int data_limit(int len, int cnt);
    int n;
    n = len + LEN_BYTES + HDR_BYTES;
    return (cnt < n) ? cnt : n;
  endfunction
endpackage

// File: rtl/txa_store.sv
module txa_store #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      push_word,
  input  logic             clear,
  input  logic [CNT_W-1:0] rd_addr,
  output logic [CNT_W-1:0] cnt,
  output logic [15:0]      len,
  output logic             space,
  output logic [7:0]       rd_byte
);
  localparam int WORDS  = FIFO_BYTES / 4;
  localparam int WIDX_W = $clog2(WORDS);

  logic [31:0] mem [WORDS];
  logic [31:0] rd_word;

  assign space = (int'(cnt) + 4) <= FIFO_BYTES;

  always_ff @(posedge clk) begin
    if (push) mem[cnt[WIDX_W+1:2]] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= '0;
    end else if (clear) begin
      cnt <= '0;
      len <= '0;
    end else if (push) begin
      cnt <= cnt + CNT_W'(4);
      if (cnt == '0) len <= push_word[15:0];
    end
  end

  assign rd_word = mem[rd_addr[WIDX_W+1:2]];
  assign rd_byte = 8'(rd_word >> {rd_addr[1:0], 3'b000});
endmodule

// File: rtl/txa_launch.sv
module txa_launch import txa_pkg::*; #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W = 12
) (
  input  logic             data_wr,
  input  logic             trig_wr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [15:0]      len,
  input  logic             space,
  input  logic             csum_auto,
  input  logic [5:0]       thr,
  output logic             push,
  output logic             len_err,
  output logic             auto_fire,
  output logic             man_fire,
  output logic [CNT_W-1:0] cnt_nx,
  output logic [15:0]      len_nx
);
  localparam int MAX_LEN = FIFO_BYTES - LEN_BYTES - HDR_BYTES;

  logic first;

  always_comb begin
    first     = (cnt == '0);
    len_err   = data_wr && first && (int'(wdata[15:0]) > MAX_LEN);
    push      = data_wr && !len_err && space;
    cnt_nx    = push ? cnt + CNT_W'(4) : cnt;
    len_nx    = (push && first) ? wdata[15:0] : len;
    auto_fire = data_wr && !len_err
                && thr_armed(int'(thr), int'(cnt_nx))
                && (int'(cnt_nx) >= need_bytes(int'(len_nx), csum_auto, FIFO_BYTES));
    man_fire  = trig_wr && wdata[0];
  end
endmodule

// File: rtl/txa_stream.sv
module txa_stream import txa_pkg::*; #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      start_len,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             pad_on,
  input  logic [7:0]       rd_byte,
  input  logic             out_ready,
  output logic [CNT_W-1:0] rd_addr,
  output logic             active,
  output logic [7:0]       out_data,
  output logic             out_last
);
  typedef logic [CNT_W-1:0] cnt_t;

  cnt_t idx, olen, lim;

  assign rd_addr  = idx + cnt_t'(LEN_BYTES);
  assign out_data = (rd_addr < lim) ? rd_byte : 8'h00;
  assign out_last = active && (idx == olen - cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      olen   <= '0;
      lim    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      idx    <= '0;
      olen   <= cnt_t'(wire_len(int'(start_len), pad_on, FIFO_BYTES));
      lim    <= cnt_t'(data_limit(int'(start_len), int'(start_cnt)));
    end else if (active && out_ready) begin
      if (out_last) active <= 1'b0;
      else          idx    <= idx + cnt_t'(1);
    end
  end
endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler import txa_pkg::*; #(
  parameter int FIFO_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        busy,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic [6:0]  raw_status,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_BYTES + 1);

  logic             pad_en, csum_en;
  logic [5:0]       thr_q;
  logic [6:0]       mask_q, raw_q;
  logic             data_wr, trig_wr, ack_wr;
  logic [CNT_W-1:0] fifo_cnt, cnt_nx, rd_addr;
  logic [15:0]      frame_len, len_nx;
  logic             push_ev, len_err_ev, auto_ev, man_ev, fire_ev, space_ok, clr_fifo;
  logic [7:0]       rd_byte;

  assign data_wr  = wr_en && (wr_addr == SEL_DATA) && !busy;
  assign trig_wr  = wr_en && (wr_addr == SEL_TRIG) && !busy;
  assign ack_wr   = wr_en && (wr_addr == SEL_ACK);
  assign fire_ev  = auto_ev || man_ev;
  assign clr_fifo = fire_ev || (ack_wr && wr_data[ERR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_en  <= 1'b0;
      csum_en <= 1'b0;
      thr_q   <= 6'(THR_OFF);
      mask_q  <= '1;
    end else if (wr_en) begin
      if (wr_addr == SEL_CTRL) begin
        pad_en  <= wr_data[PAD_BIT];
        csum_en <= wr_data[CSUM_BIT];
      end
      if (wr_addr == SEL_THR)  thr_q  <= wr_data[5:0];
      if (wr_addr == SEL_MASK) mask_q <= wr_data[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (ack_wr) begin
      raw_q <= raw_q & ~wr_data[FLAG_W-1:0];
    end else begin
      if (len_err_ev) raw_q[ERR_BIT]   <= 1'b1;
      if (fire_ev)    raw_q[EMPTY_BIT] <= 1'b1;
    end
  end

  txa_store #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .push_word(wr_data),
    .clear(clr_fifo), .rd_addr(rd_addr), .cnt(fifo_cnt), .len(frame_len),
    .space(space_ok), .rd_byte(rd_byte)
  );

  txa_launch #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_launch (
    .data_wr(data_wr), .trig_wr(trig_wr), .wdata(wr_data), .cnt(fifo_cnt),
    .len(frame_len), .space(space_ok), .csum_auto(csum_en), .thr(thr_q),
    .push(push_ev), .len_err(len_err_ev), .auto_fire(auto_ev), .man_fire(man_ev),
    .cnt_nx(cnt_nx), .len_nx(len_nx)
  );

  txa_stream #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .start(fire_ev), .start_len(len_nx),
    .start_cnt(cnt_nx), .pad_on(pad_en), .rd_byte(rd_byte),
    .out_ready(out_ready), .rd_addr(rd_addr), .active(busy),
    .out_data(out_data), .out_last(out_last)
  );

  assign out_valid  = busy;
  assign raw_status = raw_q;
  assign irq        = |(raw_q & mask_q);
endmodule

// File: rtl/txa_checker.sv
module txa_checker #(
  parameter int FIFO_BYTES = 2048,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [7:0]       out_data,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             push_ev,
  input logic             len_err_ev,
  input logic             fire_ev,
  input logic [6:0]       raw_q
);
  p_push_has_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |-> (int'(fifo_cnt) <= FIFO_BYTES - 4));

  p_count_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt[1:0] == 2'b00);

  p_bad_len_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_ev |=> (fifo_cnt == '0) && raw_q[1]);

  p_launch_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> (fifo_cnt == '0) && raw_q[2] && busy);

  p_hold_while_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  p_no_push_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !push_ev);

  p_last_ends_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind tx_frame_assembler txa_checker #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .fifo_cnt(fifo_cnt), .push_ev(push_ev), .len_err_ev(len_err_ev),
  .fire_ev(fire_ev), .raw_q(raw_q)
);

// File: tb/tx_frame_assembler_test.sv
module tx_frame_assembler_test;
  localparam int FB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_ready;
  logic        busy, out_valid, out_last, irq;
  logic [7:0]  out_data;
  logic [6:0]  raw_status;

  always #5 clk = ~clk;

  tx_frame_assembler #(.FIFO_BYTES(FB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .raw_status(raw_status), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int rdy_mode = 0;
  string cur_tag = "R1";
  logic [8:0] expq[$];
  logic [7:0] fb[256];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // sink ready pattern
  initial begin
    int rc = 0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      rc++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (rc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected byte actual=%0h expected=none", {out_last, out_data});
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk(cur_tag, int'({out_last, out_data}), int'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic fill(int len, int seed);
    fb[0] = 8'(len);
    fb[1] = 8'(len >> 8);
    for (int i = 2; i < 256; i++) fb[i] = 8'(seed + i * 13);
  endtask

  task automatic put_words(int first, int n);
    for (int w = first; w < first + n; w++)
      wr(3'd4, {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]});
  endtask

  // expected wire bytes, computed from R1, R7, R12
  task automatic expect_frame(int len, int written, bit pad);
    int olen, lim;
    olen = len + 14;
    if (pad && olen < 60) olen = 60;
    if (olen > FB - 2) olen = FB - 2;
    lim = (written < len + 16) ? written : len + 16;
    for (int i = 0; i < olen; i++) begin
      logic [7:0] b;
      b = ((i + 2) < lim) ? fb[i + 2] : 8'h00;
      expq.push_back({(i == olen - 1), b});
    end
  endtask

  task automatic drain(string tag);
    int t = 0;
    while ((busy || expq.size() != 0) && t < 4000) begin
      @(negedge clk); t++;
    end
    chk(tag, expq.size(), 0);
    chk(tag, int'(busy), 0);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 raw after reset", int'(raw_status), 0);
    chk("R10 irq after reset", int'(irq), 0);
    chk("R11 idle after reset", int'(out_valid), 0);

    // R1 R4 R5 R8: checksum on, threshold code 0
    wr(3'd2, 32'h4); wr(3'd3, 32'h0);
    cur_tag = "R1 bytes";
    fill(6, 1); expect_frame(6, 24, 0);
    put_words(0, 5);
    chk("R4 not complete at 20 of 22", int'(busy), 0);
    put_words(5, 1);
    chk("R8 busy at launch", int'(busy), 1);
    chk("R8 empty flag at launch", int'(raw_status), 4);
    chk("R10 irq with full mask", int'(irq), 1);
    drain("R1 frame done");
    wr(3'd0, 32'h7F);
    chk("R9 ack clears", int'(raw_status), 0);

    // R4 checksum off needs L+20, with backpressure
    rdy_mode = 1; wr(3'd2, 32'h0);
    cur_tag = "R4 bytes";
    fill(6, 2); expect_frame(6, 28, 0);
    put_words(0, 6);
    chk("R4 not complete at 24 of 26", int'(busy), 0);
    put_words(6, 1);
    chk("R4 launch at 28", int'(busy), 1);
    drain("R4 frame done");

    // R5 threshold code 3 = 100 bytes
    wr(3'd2, 32'h4); wr(3'd3, 32'h3);
    cur_tag = "R5 bytes";
    fill(10, 3); expect_frame(10, 100, 0);
    put_words(0, 24);
    chk("R5 complete but below threshold", int'(busy), 0);
    put_words(24, 1);
    chk("R5 launch at threshold", int'(busy), 1);
    drain("R5 frame done");

    // R6 threshold disabled, explicit request
    rdy_mode = 0; wr(3'd3, 32'd63);
    cur_tag = "R6 bytes";
    fill(8, 4);
    put_words(0, 6);
    chk("R5 code 63 holds complete frame", int'(busy), 0);
    wr(3'd5, 32'h0);
    chk("R6 request bit0 clear ignored", int'(busy), 0);
    expect_frame(8, 24, 0);
    wr(3'd5, 32'h1);
    chk("R6 request launches", int'(busy), 1);
    drain("R6 frame done");

    // R7 padding to 60
    wr(3'd2, 32'h6); wr(3'd3, 32'h0);
    cur_tag = "R7 padded bytes";
    fill(4, 5); expect_frame(4, 20, 1);
    put_words(0, 5);
    drain("R7 frame done");

    // R12 partial frame zero fill
    wr(3'd2, 32'h4); wr(3'd3, 32'd63);
    cur_tag = "R12 partial bytes";
    fill(20, 6); expect_frame(20, 12, 0);
    put_words(0, 3);
    wr(3'd5, 32'h1);
    drain("R12 frame done");
    wr(3'd0, 32'h7F);

    // R2 oversize length word dropped
    wr(3'd4, {16'hABCD, 16'd113});
    chk("R2 error flag", int'(raw_status), 2);
    chk("R10 irq on error", int'(irq), 1);
    cur_tag = "R2 next word is length";
    fill(2, 7); expect_frame(2, 4, 0);
    put_words(0, 1);
    wr(3'd5, 32'h1);
    drain("R2 frame done");
    wr(3'd0, 32'h2);
    chk("R9 ack clears only error", int'(raw_status), 4);

    // R10 mask gating
    wr(3'd1, 32'h0);
    chk("R10 masked irq", int'(irq), 0);
    wr(3'd1, 32'h4);
    chk("R10 irq via bit 2 mask", int'(irq), 1);
    wr(3'd1, 32'h7F);
    wr(3'd0, 32'h7F);

    // R9 ack bit 1 empties store
    fill(30, 8); put_words(0, 2);
    wr(3'd0, 32'h2);
    cur_tag = "R9 bytes after flush";
    fill(3, 9); expect_frame(3, 8, 0);
    put_words(0, 2);
    wr(3'd5, 32'h1);
    drain("R9 frame done");

    // R4 cap at store size: L=112, checksum off, code 0
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    cur_tag = "R4 capped bytes";
    fill(112, 10); expect_frame(112, 128, 0);
    put_words(0, 31);
    chk("R4 not complete at 124", int'(busy), 0);
    put_words(31, 1);
    chk("R4 capped need launches at 128", int'(busy), 1);
    drain("R4 capped frame done");

    // R3 write into full store dropped
    wr(3'd3, 32'd63);
    cur_tag = "R3 bytes after overflow";
    fill(112, 11); expect_frame(112, 128, 0);
    put_words(0, 32);
    wr(3'd4, 32'hDEADBEEF);
    chk("R3 no launch", int'(busy), 0);
    wr(3'd5, 32'h1);
    drain("R3 frame done");

    // R11 stall and writes while busy ignored
    rdy_mode = 2;
    @(posedge clk);
    cur_tag = "R11 empty frame bytes";
    fill(0, 0); expect_frame(0, 0, 0);
    wr(3'd5, 32'h1);
    chk("R6 empty store launches", int'(busy), 1);
    wr(3'd4, 32'h5);
    wr(3'd5, 32'h1);
    chk("R11 valid held while stalled", int'(out_valid), 1);
    chk("R11 data held while stalled", int'(out_data), 0);
    rdy_mode = 0;
    drain("R11 frame done");
    expect_frame(0, 0, 0);
    wr(3'd5, 32'h1);
    drain("R11 busy write was ignored");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule